// File: doc/BRIEF.md
# Dual-Accumulator Fixed-Point Multiply-Accumulate Unit

This unit multiplies two 32-bit operands and sends the product to one of three places: a 32-bit register result, the foreground accumulator or the background accumulator. Both accumulators are 80 bits wide. A product can be written as it is, added to an accumulator, or subtracted from one. Each issued operation chooses whether its operands are signed or unsigned, and whether the arithmetic is fractional or integer.

Further operations work on a selected accumulator. It can be saturated or rounded into a register or back into itself, cleared to zero, loaded from an operand, or read out. Every operation is issued in one cycle with an opcode. The register result and a valid flag appear one cycle later.

A sticky overflow flag records any saturation that had to clamp. The register file and floating-point arithmetic are outside this block.

Top module: `dmac_unit`

## Requirements
- R1: `valid_o` is high exactly in the cycle after a cycle with `valid_i` high, and low after a cycle with `valid_i` low. The register result of an issued operation is on `res_o` in that same cycle.
- R2: `op_i` codes are: 0 multiply to register, 1 multiply to accumulator, 2 add to register, 3 add to accumulator, 4 subtract to register, 5 subtract to accumulator, 6 saturate to register, 7 saturate to accumulator, 8 round to register, 9 round to accumulator, 10 clear, 11 load, 12 read. The product is formed from operands that are sign-extended when `signed_i`=1 and zero-extended when `signed_i`=0. When `frac_i`=1 the product is then shifted left by one bit. Code 0 returns product bits [63:32] when `frac_i`=1 and bits [31:0] when `frac_i`=0.
- R3: Code 1 writes the 80-bit extended product into the accumulator chosen by `acc_sel_i` (0 foreground, 1 background). The other accumulator is left unchanged.
- R4: Codes 3 and 5 replace the selected accumulator with that accumulator plus or minus the product, computed modulo 2^80.
- R5: Codes 2 and 4 return the field (as chosen in R2) of the accumulator plus or minus the product. No accumulator changes.
- R6: Code 6 clamps the selected accumulator to the range of the target format and returns the field. The ranges are: signed integer [-2^31, 2^31-1], unsigned integer [0, 2^32-1], signed fraction [-2^63, 2^63-1], unsigned fraction [0, 2^64-1]. For the unsigned formats the accumulator is read as an unsigned 80-bit value.
- R7: Code 7 writes the clamped value of R6 back into the selected accumulator. A value already inside the range is left as it is.
- R8: Code 8 adds 2^31 to the selected accumulator and returns bits [63:32] of the sum. Code 9 writes the sum back with bits [31:0] cleared. Rounding always uses the fraction position.
- R9: Code 10 sets the selected accumulator to zero.
- R10: Code 11 loads `a_i` into the selected accumulator, sign-extended when `signed_i`=1 and zero-extended otherwise. Code 12 returns bits [31:0] of the selected accumulator.
- R11: `ovf_o` sets when code 6 or 7 has to clamp, and it stays set until reset.
- R12: After reset, `valid_o`, `res_o`, `ovf_o` and both accumulators are zero.
- R13: `res_o` holds its value in cycles without an issue and after codes 1, 3, 5, 7, 9, 10 and 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Issue strobe |
| op_i | input | 4 | Opcode (R2) |
| acc_sel_i | input | 1 | Accumulator select: 0 foreground, 1 background |
| signed_i | input | 1 | Signed operands / format |
| frac_i | input | 1 | Fractional mode |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| valid_o | output | 1 | Result valid, one cycle after issue |
| res_o | output | 32 | Register result |
| ovf_o | output | 1 | Sticky saturation flag |

## Verification
A wrong accumulator value stays hidden until an operation reads that accumulator. A read, add-to-register, saturate or round then shows the error on `res_o` one cycle after issue. The bench therefore follows every accumulator write closely with register-returning operations on both accumulators. A fractional add-to-register with a zero product exposes bits [63:32]. A saturate exposes bits [79:64] through whether it clamps and through `ovf_o`.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  typedef enum logic [3:0] {
    OP_MULR = 4'd0,  OP_MULA = 4'd1,  OP_MACR = 4'd2,  OP_MACA = 4'd3,
    OP_MSBR = 4'd4,  OP_MSBA = 4'd5,  OP_SATR = 4'd6,  OP_SATA = 4'd7,
    OP_RNDR = 4'd8,  OP_RNDA = 4'd9,  OP_CLR  = 4'd10, OP_LOAD = 4'd11,
    OP_READ = 4'd12
  } dmac_op_e;
endpackage

// File: rtl/dmac_mult.sv
module dmac_mult #(
  parameter int DW = 32,
  parameter int AW = 80
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          sgn_i,
  input  logic          frac_i,
  output logic [AW-1:0] prod_o
);
  localparam int XW = DW + 1;
  localparam int MW = 2 * XW;

  logic signed [XW-1:0] ax, bx;
  logic signed [MW-1:0] ae, be, m;
  logic signed [AW-1:0] ext;

  assign ax  = {sgn_i & a_i[DW-1], a_i};
  assign bx  = {sgn_i & b_i[DW-1], b_i};
  assign ae  = MW'(ax);
  assign be  = MW'(bx);
  assign m   = ae * be;
  assign ext = AW'(m);
  // fractional: drop the redundant sign bit
  assign prod_o = frac_i ? {ext[AW-2:0], 1'b0} : ext;
endmodule

// File: rtl/dmac_conv.sv
module dmac_conv #(
  parameter int DW = 32,
  parameter int AW = 80
) (
  input  logic [AW-1:0] v_i,
  input  logic          sgn_i,
  input  logic          frac_i,
  output logic [DW-1:0] fld_o,
  output logic [AW-1:0] sat_o,
  output logic [DW-1:0] sat_fld_o,
  output logic          hit_o,
  output logic [AW-1:0] rnd_o,
  output logic [DW-1:0] rnd_fld_o
);
  localparam int PW = 2 * DW;

  logic s_int_ok, s_frc_ok, u_int_ok, u_frc_ok, in_rng;
  logic [AW-1:0] smax, smin, umax, lim, r;

  assign s_int_ok = (~|v_i[AW-1:DW-1]) | (&v_i[AW-1:DW-1]);
  assign s_frc_ok = (~|v_i[AW-1:PW-1]) | (&v_i[AW-1:PW-1]);
  assign u_int_ok = ~|v_i[AW-1:DW];
  assign u_frc_ok = ~|v_i[AW-1:PW];
  assign in_rng   = sgn_i ? (frac_i ? s_frc_ok : s_int_ok)
                          : (frac_i ? u_frc_ok : u_int_ok);

  always_comb begin
    if (frac_i) begin
      smax = {{(AW-PW+1){1'b0}}, {(PW-1){1'b1}}};
      smin = {{(AW-PW+1){1'b1}}, {(PW-1){1'b0}}};
      umax = {{(AW-PW){1'b0}}, {PW{1'b1}}};
    end else begin
      smax = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
      smin = {{(AW-DW+1){1'b1}}, {(DW-1){1'b0}}};
      umax = {{(AW-DW){1'b0}}, {DW{1'b1}}};
    end
    lim = sgn_i ? (v_i[AW-1] ? smin : smax) : umax;
  end

  assign hit_o     = ~in_rng;
  assign sat_o     = in_rng ? v_i : lim;
  assign fld_o     = frac_i ? v_i[PW-1:DW] : v_i[DW-1:0];
  assign sat_fld_o = frac_i ? sat_o[PW-1:DW] : sat_o[DW-1:0];

  assign r         = v_i + (AW'(1) << (DW-1));
  assign rnd_o     = {r[AW-1:DW], {DW{1'b0}}};
  assign rnd_fld_o = r[PW-1:DW];
endmodule

// File: rtl/dmac_unit.sv
module dmac_unit
  import dmac_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 80
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [3:0]    op_i,
  input  logic          acc_sel_i,
  input  logic          signed_i,
  input  logic          frac_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic          valid_o,
  output logic [DW-1:0] res_o,
  output logic          ovf_o
);
  logic [AW-1:0] fg_q, bg_q, acc_cur, prod, sum, dif, v, acc_nx;
  logic [AW-1:0] sat_v, rnd_v;
  logic [DW-1:0] fld, sat_fld, rnd_fld, res_q, res_nx;
  logic          hit, acc_we, sat_use, vld_q, ovf_q;
  dmac_op_e      op;

  assign op      = dmac_op_e'(op_i);
  assign acc_cur = acc_sel_i ? bg_q : fg_q;
  assign sum     = acc_cur + prod;
  assign dif     = acc_cur - prod;

  dmac_mult #(.DW(DW), .AW(AW)) u_mult (
    .a_i(a_i), .b_i(b_i), .sgn_i(signed_i), .frac_i(frac_i), .prod_o(prod)
  );

  always_comb begin
    unique case (op)
      OP_MULR, OP_MULA: v = prod;
      OP_MACR, OP_MACA: v = sum;
      OP_MSBR, OP_MSBA: v = dif;
      default:          v = acc_cur;
    endcase
  end

  dmac_conv #(.DW(DW), .AW(AW)) u_conv (
    .v_i(v), .sgn_i(signed_i), .frac_i(frac_i),
    .fld_o(fld), .sat_o(sat_v), .sat_fld_o(sat_fld), .hit_o(hit),
    .rnd_o(rnd_v), .rnd_fld_o(rnd_fld)
  );

  always_comb begin
    acc_nx  = acc_cur;
    acc_we  = 1'b0;
    res_nx  = res_q;
    sat_use = 1'b0;
    case (op)
      OP_MULR, OP_MACR, OP_MSBR: res_nx = fld;
      OP_MULA, OP_MACA, OP_MSBA: begin acc_nx = v; acc_we = 1'b1; end
      OP_SATR: begin res_nx = sat_fld; sat_use = 1'b1; end
      OP_SATA: begin acc_nx = sat_v; acc_we = 1'b1; sat_use = 1'b1; end
      OP_RNDR: res_nx = rnd_fld;
      OP_RNDA: begin acc_nx = rnd_v; acc_we = 1'b1; end
      OP_CLR:  begin acc_nx = '0; acc_we = 1'b1; end
      OP_LOAD: begin
        acc_nx = {{(AW-DW){signed_i & a_i[DW-1]}}, a_i};
        acc_we = 1'b1;
      end
      OP_READ: res_nx = acc_cur[DW-1:0];
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fg_q  <= '0;
      bg_q  <= '0;
      res_q <= '0;
      vld_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      vld_q <= valid_i;
      if (valid_i) begin
        res_q <= res_nx;
        if (acc_we && acc_sel_i)  bg_q <= acc_nx;
        if (acc_we && !acc_sel_i) fg_q <= acc_nx;
        if (sat_use && hit)       ovf_q <= 1'b1;
      end
    end
  end

  assign valid_o = vld_q;
  assign res_o   = res_q;
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/dmac_unit_chk.sv
module dmac_unit_chk #(
  parameter int DW = 32,
  parameter int AW = 80
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic [3:0]    op_i,
  input logic          acc_sel_i,
  input logic          valid_o,
  input logic [DW-1:0] res_o,
  input logic          ovf_o,
  input logic [AW-1:0] fg_q,
  input logic [AW-1:0] bg_q
);
  a_r1_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r11_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
  a_r13_res_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(res_o));
  a_r9_clear_fg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == dmac_pkg::OP_CLR && !acc_sel_i) |=> (fg_q == '0));
  a_r9_clear_bg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == dmac_pkg::OP_CLR && acc_sel_i) |=> (bg_q == '0));
  a_r3_bg_untouched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !acc_sel_i) |=> $stable(bg_q));
  a_r3_fg_untouched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && acc_sel_i) |=> $stable(fg_q));
endmodule

bind dmac_unit dmac_unit_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
  .acc_sel_i(acc_sel_i), .valid_o(valid_o), .res_o(res_o), .ovf_o(ovf_o),
  .fg_q(fg_q), .bg_q(bg_q)
);

// File: tb/tb_dmac_unit.sv
module tb_dmac_unit;
  import dmac_pkg::*;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic        acc_sel_i = 1'b0, signed_i = 1'b0, frac_i = 1'b0;
  logic [31:0] a_i = '0, b_i = '0;
  logic        valid_o, ovf_o;
  logic [31:0] res_o;

  int n_chk = 0, n_fail = 0;
  logic finished = 1'b0;

  logic [79:0] m_fg = '0, m_bg = '0;
  logic [31:0] m_res = '0;
  logic        m_ovf = 1'b0;

  always #5 clk_i = ~clk_i;

  dmac_unit dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .acc_sel_i(acc_sel_i), .signed_i(signed_i), .frac_i(frac_i),
    .a_i(a_i), .b_i(b_i), .valid_o(valid_o), .res_o(res_o), .ovf_o(ovf_o)
  );

  function automatic string tag_of(dmac_op_e op);
    case (op)
      OP_MULR: return "R2";
      OP_MULA: return "R3";
      OP_MACA, OP_MSBA: return "R4";
      OP_MACR, OP_MSBR: return "R5";
      OP_SATR: return "R6";
      OP_SATA: return "R7";
      OP_RNDR, OP_RNDA: return "R8";
      OP_CLR:  return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [79:0] m_prod(logic [31:0] a, logic [31:0] b,
                                         logic sgn, logic frc);
    logic signed [79:0] x, y, p;
    x = sgn ? {{48{a[31]}}, a} : {48'b0, a};
    y = sgn ? {{48{b[31]}}, b} : {48'b0, b};
    p = x * y;
    if (frc) p = p * 2;
    return p;
  endfunction

  function automatic logic [79:0] m_sat(logic [79:0] v, logic sgn, logic frc,
                                        output logic hit);
    logic signed [79:0] hi, lo;
    logic [79:0] um;
    hit = 1'b0;
    if (sgn) begin
      hi = (80'sd1 <<< (frc ? 63 : 31)) - 80'sd1;
      lo = -hi - 80'sd1;
      if ($signed(v) > hi) begin hit = 1'b1; return hi; end
      if ($signed(v) < lo) begin hit = 1'b1; return lo; end
      return v;
    end
    um = (80'd1 << (frc ? 64 : 32)) - 80'd1;
    if (v > um) begin hit = 1'b1; return um; end
    return v;
  endfunction

  function automatic logic [31:0] m_fld(logic [79:0] v, logic frc);
    return frc ? v[63:32] : v[31:0];
  endfunction

  task automatic check(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input dmac_op_e op, input logic sel, input logic sgn,
                        input logic frc, input logic [31:0] a, input logic [31:0] b);
    logic [79:0] acc, p, w, s, r;
    logic we, hit;
    @(negedge clk_i);
    valid_i = 1'b1; op_i = op; acc_sel_i = sel; signed_i = sgn; frac_i = frc;
    a_i = a; b_i = b;
    @(posedge clk_i);
    #1;
    valid_i = 1'b0;
    acc = sel ? m_bg : m_fg;
    p   = m_prod(a, b, sgn, frc);
    we  = 1'b0; w = acc;
    s   = m_sat(acc, sgn, frc, hit);
    r   = acc + (80'd1 << 31);
    case (op)
      OP_MULR: m_res = m_fld(p, frc);
      OP_MULA: begin w = p; we = 1'b1; end
      OP_MACR: m_res = m_fld(acc + p, frc);
      OP_MACA: begin w = acc + p; we = 1'b1; end
      OP_MSBR: m_res = m_fld(acc - p, frc);
      OP_MSBA: begin w = acc - p; we = 1'b1; end
      OP_SATR: begin m_res = m_fld(s, frc); m_ovf |= hit; end
      OP_SATA: begin w = s; we = 1'b1; m_ovf |= hit; end
      OP_RNDR: m_res = r[63:32];
      OP_RNDA: begin w = {r[79:32], 32'b0}; we = 1'b1; end
      OP_CLR:  begin w = '0; we = 1'b1; end
      OP_LOAD: begin w = sgn ? {{48{a[31]}}, a} : {48'b0, a}; we = 1'b1; end
      OP_READ: m_res = acc[31:0];
      default: ;
    endcase
    if (we) begin
      if (sel) m_bg = w; else m_fg = w;
    end
    n_chk++;
    if (valid_o !== 1'b1 || res_o !== m_res || ovf_o !== m_ovf) begin
      n_fail++;
      $display("FAIL %s op=%0d res=%h exp=%h valid=%b ovf=%b exp_ovf=%b (R1/R11)",
               tag_of(op), op, res_o, m_res, valid_o, ovf_o, m_ovf);
    end
  endtask

  logic [31:0] vals [8];

  initial begin
    vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001;
    vals[2] = 32'hFFFF_FFFF; vals[3] = 32'h7FFF_FFFF;
    vals[4] = 32'h8000_0000; vals[5] = 32'h4000_0000;
    vals[6] = 32'h0000_0003; vals[7] = 32'h1234_5678;
    repeat (3) @(posedge clk_i);
    #1;
    // R12: reset state
    check(valid_o === 1'b0, "R12 valid", {31'b0, valid_o}, 32'h0);
    check(res_o === 32'h0, "R12 res", res_o, 32'h0);
    check(ovf_o === 1'b0, "R12 ovf", {31'b0, ovf_o}, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    run_op(OP_READ, 1'b0, 1'b0, 1'b0, '0, '0);
    check(res_o === 32'h0, "R12 fg zero", res_o, 32'h0);
    run_op(OP_READ, 1'b1, 1'b0, 1'b0, '0, '0);
    check(res_o === 32'h0, "R12 bg zero", res_o, 32'h0);

    // R10: load with sign / zero extension, seen through bits [63:32]
    run_op(OP_LOAD, 1'b0, 1'b1, 1'b0, 32'h8000_0000, '0);
    run_op(OP_READ, 1'b0, 1'b0, 1'b0, '0, '0);
    check(res_o === 32'h8000_0000, "R10 read", res_o, 32'h8000_0000);
    run_op(OP_MACR, 1'b0, 1'b0, 1'b1, '0, '0);
    check(res_o === 32'hFFFF_FFFF, "R10 sign ext", res_o, 32'hFFFF_FFFF);
    run_op(OP_LOAD, 1'b0, 1'b0, 1'b0, 32'h8000_0000, '0);
    run_op(OP_MACR, 1'b0, 1'b0, 1'b1, '0, '0);
    check(res_o === 32'h0, "R10 zero ext", res_o, 32'h0);

    // R13: result holds while idle and across accumulator-only ops
    repeat (3) @(posedge clk_i);
    #1;
    check(res_o === 32'h0 && valid_o === 1'b0, "R13 idle hold", res_o, 32'h0);
    run_op(OP_MULR, 1'b0, 1'b0, 1'b0, 32'd7, 32'd6);
    check(res_o === 32'd42, "R2 int product", res_o, 32'd42);
    run_op(OP_CLR, 1'b1, 1'b0, 1'b0, '0, '0);
    check(res_o === 32'd42, "R13 hold after clear", res_o, 32'd42);

    // R6/R11: in-range saturate leaves flag clear
    run_op(OP_SATR, 1'b1, 1'b0, 1'b0, '0, '0);
    check(ovf_o === 1'b0, "R11 no clamp", {31'b0, ovf_o}, 32'h0);
    // R11: grow bg past 2^64 unsigned, then clamp
    for (int k = 0; k < 5; k++)
      run_op(OP_MACA, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_op(OP_SATR, 1'b1, 1'b0, 1'b1, '0, '0);
    check(res_o === 32'hFFFF_FFFF, "R6 unsigned frac clamp", res_o, 32'hFFFF_FFFF);
    check(ovf_o === 1'b1, "R11 set", {31'b0, ovf_o}, 32'h1);
    // R6: signed fraction -1 * -1 overflows to +max
    run_op(OP_MULA, 1'b0, 1'b1, 1'b1, 32'h8000_0000, 32'h8000_0000);
    run_op(OP_SATR, 1'b0, 1'b1, 1'b1, '0, '0);
    check(res_o === 32'h7FFF_FFFF, "R6 signed frac clamp", res_o, 32'h7FFF_FFFF);
    run_op(OP_CLR, 1'b0, 1'b0, 1'b0, '0, '0);
    check(ovf_o === 1'b1, "R11 sticky", {31'b0, ovf_o}, 32'h1);
    // R8: rounding carries into the kept field
    run_op(OP_LOAD, 1'b0, 1'b0, 1'b0, 32'h8000_0000, '0);
    run_op(OP_RNDR, 1'b0, 1'b0, 1'b0, '0, '0);
    check(res_o === 32'h1, "R8 round up", res_o, 32'h1);

    // sweep: all operand pairs over all four format combinations
    for (int md = 0; md < 4; md++) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          logic sg, fr;
          sg = md[0]; fr = md[1];
          run_op(OP_MULR, 1'b0, sg, fr, vals[i], vals[j]);
          run_op(OP_MULA, j[0], sg, fr, vals[i], vals[j]);
          run_op(OP_MACA, 1'b0, sg, fr, vals[i], vals[j]);
          run_op(OP_MSBA, 1'b1, sg, fr, vals[j], vals[i]);
          run_op(OP_MACR, 1'b1, sg, fr, vals[i], vals[i]);
          run_op(OP_MSBR, 1'b0, sg, fr, vals[j], vals[j]);
          run_op(OP_SATR, i[0], sg, fr, '0, '0);
          run_op(OP_RNDR, j[1], sg, fr, '0, '0);
          if (j == 3) run_op(OP_SATA, 1'b0, sg, fr, '0, '0);
          if (j == 5) run_op(OP_RNDA, 1'b1, sg, fr, '0, '0);
          if (j == 6) run_op(OP_LOAD, 1'b0, sg, fr, vals[i], '0);
          if (j == 7) run_op(OP_CLR, 1'b1, sg, fr, '0, '0);
          run_op(OP_READ, 1'b0, sg, fr, '0, '0);
          run_op(OP_READ, 1'b1, sg, fr, '0, '0);
          run_op(OP_MACR, i[1], sg, 1'b1, '0, '0);
        end
      end
    end

    if (!finished) begin
      finished = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule